// File: doc/BRIEF.md
# Paged Word-Address Counter with Deferred Page Commit

This block sits behind a two-wire serial protocol engine in front of a 512-byte store. The store is split into 32 pages of 16 bytes. The block keeps the current word address and applies two wrap rules. Writes step only the byte-in-page bits, so the address stays inside one page. Reads step the whole address, so it runs across the whole store and wraps from the top back to zero.

Data bytes from the protocol engine are not written to the store straight away. Each byte goes into a 16-entry page buffer, and a per-position valid mask records which positions have been filled. When the engine reports a STOP, the valid bytes are copied into the synchronous RAM. A busy flag is then held for a fixed write-cycle time, counted in system clocks. While the flag is high, every input strobe is ignored.

A write-protect input, sampled at STOP, discards the buffered bytes instead of committing them.

Top module: `page_commit_ctrl`

## Requirements
- R1: After reset, `busy` is 0 and `cur_addr` is 0x000.
- R2: When `load_en` is accepted, `cur_addr` takes `load_addr` on the next clock edge. The accepted strobe has priority load_en, then wr_en, then rd_adv. A `stop` in the same cycle overrides all three.
- R3: Each accepted `wr_en` buffers `wr_data` at byte position `cur_addr[3:0]`. It then increments only `cur_addr[3:0]`, so position 15 is followed by position 0 and `cur_addr[8:4]` (the page) is held.
- R4: When more than 16 bytes are written in one sequence, a later byte replaces the earlier byte buffered at the same wrapped position.
- R5: A commit changes only the positions that were written. All other bytes of the page keep their stored value.
- R6: Each accepted `rd_adv` increments all 9 bits of `cur_addr`, wrapping from 0x1FF to 0x000.
- R7: `rd_data` shows the stored byte at `cur_addr` one clock edge after `cur_addr` settles.
- R8: A `stop` with at least one buffered byte and `wp` low commits the page. `busy` goes high on that edge and stays high for exactly WR_CYCLES clocks.
- R9: A `stop` with `wp` high does not commit and does not assert `busy`. It also discards the buffered bytes, so a later `stop` with `wp` low commits nothing.
- R10: A `stop` with no buffered bytes (for example after only an address load) does not assert `busy`.
- R11: While `busy` is high, `load_en`, `wr_en`, `rd_adv` and `stop` are ignored. `cur_addr` is unchanged and no byte is buffered.
- R12: The valid mask is cleared when a commit ends, so a second `stop` with no new bytes does not assert `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| load_en | input | 1 | Load the word address from `load_addr` |
| load_addr | input | 9 | Word address to load |
| wr_en | input | 1 | Buffer one data byte |
| wr_data | input | 8 | Data byte to buffer |
| rd_adv | input | 1 | Advance the read address by one |
| stop | input | 1 | End of sequence; commit if any bytes are buffered |
| wp | input | 1 | Write protect; high blocks the commit |
| busy | output | 1 | Write cycle in progress |
| cur_addr | output | 9 | Current word address |
| rd_data | output | 8 | Stored byte at `cur_addr` |

## Verification
An accepted strobe moves `cur_addr` on the edge that samples it, and the bench checks it at the next falling edge. `rd_data` is registered once more, so each read check lets one idle cycle pass after the address settles before comparing. `busy` rises on the edge that samples `stop`; the bench counts the falling edges at which it is high and expects exactly WR_CYCLES of them. Committed contents are read back only after `busy` has dropped, and they are compared with a byte model kept in the bench.

// File: rtl/pc_pkg.sv
package pc_pkg;
    localparam int DEF_ADDR_W    = 9;
    localparam int DEF_PAGE_W    = 4;
    localparam int DEF_DATA_W    = 8;
    localparam int DEF_WR_CYCLES = 500000;
endpackage

// File: rtl/pc_page_buf.sv
module pc_page_buf #(
    parameter int PAGE_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [PAGE_W-1:0] wr_idx,
    input  logic [DATA_W-1:0] wr_byte,
    input  logic              clr,
    input  logic [PAGE_W-1:0] rd_idx,
    output logic [DATA_W-1:0] rd_byte,
    output logic [(1<<PAGE_W)-1:0] valid
);
    localparam int SLOTS = 1 << PAGE_W;

    logic [DATA_W-1:0] bytes_d [SLOTS];
    logic [DATA_W-1:0] bytes_q [SLOTS];
    logic [SLOTS-1:0]  mask_d, mask_q;

    always_comb begin
        bytes_d = bytes_q;
        mask_d  = mask_q;
        if (clr) begin
            mask_d = '0;
        end else if (wr) begin
            bytes_d[wr_idx] = wr_byte;
            mask_d[wr_idx]  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
            for (int i = 0; i < SLOTS; i++) bytes_q[i] <= '0;
        end else begin
            mask_q  <= mask_d;
            bytes_q <= bytes_d;
        end
    end

    assign rd_byte = bytes_q[rd_idx];
    assign valid   = mask_q;
endmodule

// File: rtl/pc_word_ram.sv
module pc_word_ram #(
    parameter int ADDR_W = 9,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int WORDS = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [WORDS];
    logic [DATA_W-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
        rdata_q <= cells[raddr];
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/page_commit_ctrl.sv
module page_commit_ctrl #(
    parameter int ADDR_W    = pc_pkg::DEF_ADDR_W,
    parameter int PAGE_W    = pc_pkg::DEF_PAGE_W,
    parameter int DATA_W    = pc_pkg::DEF_DATA_W,
    parameter int WR_CYCLES = pc_pkg::DEF_WR_CYCLES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_adv,
    input  logic              stop,
    input  logic              wp,
    output logic              busy,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int PAGE_BYTES = 1 << PAGE_W;
    localparam int SEL_W      = ADDR_W - PAGE_W;
    localparam int CNT_W      = $clog2(WR_CYCLES);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(WR_CYCLES - 1);
    localparam logic [CNT_W-1:0] SLOT_LIM = CNT_W'(PAGE_BYTES);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [SEL_W-1:0]  page;
        logic              busy;
        logic [CNT_W-1:0]  cnt;
    } ctrl_t;

    ctrl_t st_d, st_q;

    logic                  buf_wr, buf_clr, ram_we;
    logic [DATA_W-1:0]     buf_byte;
    logic [PAGE_BYTES-1:0] buf_valid;
    logic [PAGE_W-1:0]     slot;

    assign slot = st_q.cnt[PAGE_W-1:0];

    always_comb begin
        st_d    = st_q;
        buf_wr  = 1'b0;
        buf_clr = 1'b0;
        ram_we  = 1'b0;
        if (st_q.busy) begin
            // commit phase: walk the slots during the first PAGE_BYTES counts
            if (st_q.cnt < SLOT_LIM && buf_valid[slot]) ram_we = 1'b1;
            if (st_q.cnt == LAST_CNT) begin
                st_d.busy = 1'b0;
                buf_clr   = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end else if (stop) begin
            if (wp) begin
                buf_clr = 1'b1;
            end else if (|buf_valid) begin
                st_d.busy = 1'b1;
                st_d.cnt  = '0;
            end
        end else if (load_en) begin
            st_d.addr = load_addr;
        end else if (wr_en) begin
            buf_wr    = 1'b1;
            st_d.page = st_q.addr[ADDR_W-1:PAGE_W];
            st_d.addr = {st_q.addr[ADDR_W-1:PAGE_W], st_q.addr[PAGE_W-1:0] + 1'b1};
        end else if (rd_adv) begin
            st_d.addr = st_q.addr + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    pc_page_buf #(.PAGE_W(PAGE_W), .DATA_W(DATA_W)) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (buf_wr),
        .wr_idx  (st_q.addr[PAGE_W-1:0]),
        .wr_byte (wr_data),
        .clr     (buf_clr),
        .rd_idx  (slot),
        .rd_byte (buf_byte),
        .valid   (buf_valid)
    );

    pc_word_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .waddr ({st_q.page, slot}),
        .wdata (buf_byte),
        .raddr (st_q.addr),
        .rdata (rd_data)
    );

    assign busy     = st_q.busy;
    assign cur_addr = st_q.addr;
endmodule

// File: rtl/pc_checker.sv
module pc_checker #(
    parameter int ADDR_W    = 9,
    parameter int PAGE_W    = 4,
    parameter int WR_CYCLES = 500000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              load_en,
    input logic              wr_en,
    input logic              rd_adv,
    input logic              stop,
    input logic              wp,
    input logic              busy,
    input logic [ADDR_W-1:0] cur_addr
);
    logic [31:0] busy_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    busy_len <= '0;
        else if (busy) busy_len <= busy_len + 1;
        else           busy_len <= '0;
    end

    // R8: busy only starts from a stop
    assert_busy_from_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(stop));

    // R8: busy never outlasts the write-cycle time
    assert_busy_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy_len <= WR_CYCLES);

    // R9: a protected stop never raises busy
    assert_wp_no_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (stop && wp && !busy) |=> !busy);

    // R11: address frozen while busy
    assert_addr_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(cur_addr));

    // R3: write steps the byte bits and keeps the page
    assert_write_in_page_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !load_en && !stop && !busy) |=>
        (cur_addr[ADDR_W-1:PAGE_W] == $past(cur_addr[ADDR_W-1:PAGE_W]) &&
         cur_addr[PAGE_W-1:0] == $past(cur_addr[PAGE_W-1:0]) + 1'b1));

    // R6: read advance steps the full address
    assert_read_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_adv && !wr_en && !load_en && !stop && !busy) |=>
        cur_addr == $past(cur_addr) + 1'b1);
endmodule

bind page_commit_ctrl pc_checker #(
    .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .WR_CYCLES(WR_CYCLES)
) u_pc_checker (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .wr_en(wr_en),
    .rd_adv(rd_adv), .stop(stop), .wp(wp), .busy(busy), .cur_addr(cur_addr)
);

// File: tb/page_commit_ctrl_test.sv
module page_commit_ctrl_test;
    localparam int WRC = 40;

    logic       clk = 0;
    logic       rst_n = 0;
    logic       load_en = 0, wr_en = 0, rd_adv = 0, stop = 0, wp = 0;
    logic [8:0] load_addr = '0;
    logic [7:0] wr_data = '0;
    logic       busy;
    logic [8:0] cur_addr;
    logic [7:0] rd_data;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  done     = 0;
    logic [7:0] model [512];

    always #2.5 clk = ~clk;

    page_commit_ctrl #(.WR_CYCLES(WRC)) uut (
        .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_addr(load_addr),
        .wr_en(wr_en), .wr_data(wr_data), .rd_adv(rd_adv), .stop(stop), .wp(wp),
        .busy(busy), .cur_addr(cur_addr), .rd_data(rd_data)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // drive one cycle of strobes at a falling edge, return at the next one
    task automatic cyc(input logic l, input logic [8:0] a, input logic w,
                       input logic [7:0] d, input logic r, input logic s);
        load_en = l; load_addr = a; wr_en = w; wr_data = d; rd_adv = r; stop = s;
        @(negedge clk);
        load_en = 0; wr_en = 0; rd_adv = 0; stop = 0;
    endtask

    task automatic idle(); cyc(0, '0, 0, '0, 0, 0); endtask
    task automatic load(input logic [8:0] a); cyc(1, a, 0, '0, 0, 0); endtask
    task automatic wbyte(input logic [7:0] d); cyc(0, '0, 1, d, 0, 0); endtask
    task automatic do_stop(); cyc(0, '0, 0, '0, 0, 1); endtask

    task automatic wait_free();
        while (busy) @(negedge clk);
    endtask

    task automatic read_cmp(input string req, input logic [8:0] a, input int n);
        load(a);
        for (int i = 0; i < n; i++) begin
            idle();
            check(req, rd_data, model[(a + i) % 512]);
            cyc(0, '0, 0, '0, 1, 0);
        end
    endtask

    task automatic t_reset();
        check("R1 busy", busy, 0);
        check("R1 addr", cur_addr, 0);
    endtask

    task automatic t_full_page();
        int cnt;
        load(9'h025);
        check("R2 load", cur_addr, 9'h025);
        load(9'h030);
        for (int i = 0; i < 16; i++) begin
            wbyte(8'hA0 + 8'(i));
            model[9'h030 + i] = 8'hA0 + 8'(i);
        end
        check("R3 wrap in page", cur_addr, 9'h030);
        do_stop();
        check("R8 busy rises", busy, 1);
        cnt = 0;
        while (busy) begin cnt++; @(negedge clk); end
        check("R8 busy length", cnt, WRC);
        read_cmp("R7 read back", 9'h030, 16);
        check("R6 cross page", cur_addr, 9'h040);
    endtask

    task automatic t_overflow();
        load(9'h03E);
        for (int i = 0; i < 18; i++) begin
            wbyte(8'h10 + 8'(i));
            model[{5'h03, 4'(4'hE + i)}] = 8'h10 + 8'(i);
        end
        check("R3 page held", cur_addr, 9'h030);
        do_stop();
        wait_free();
        read_cmp("R4 overwrite", 9'h030, 16);
    endtask

    task automatic t_partial();
        load(9'h034);
        wbyte(8'h55); model[9'h034] = 8'h55;
        wbyte(8'h66); model[9'h035] = 8'h66;
        check("R3 step", cur_addr, 9'h036);
        do_stop();
        wait_free();
        read_cmp("R5 partial keep", 9'h030, 16);
    endtask

    task automatic t_protect();
        load(9'h030);
        wp = 1;
        wbyte(8'h99);
        do_stop();
        check("R9 no busy on wp", busy, 0);
        wp = 0;
        do_stop();
        check("R9 discarded", busy, 0);
        read_cmp("R9 array intact", 9'h030, 2);
    endtask

    task automatic t_empty_stop();
        load(9'h100);
        do_stop();
        check("R10 empty stop", busy, 0);
    endtask

    task automatic t_mask_clear();
        load(9'h150);
        wbyte(8'h3C); model[9'h150] = 8'h3C;
        do_stop();
        wait_free();
        do_stop();
        check("R12 mask cleared", busy, 0);
        read_cmp("R12 committed", 9'h150, 1);
    endtask

    task automatic t_read_wrap();
        load(9'h1FF);
        cyc(0, '0, 0, '0, 1, 0);
        check("R6 wrap to zero", cur_addr, 9'h000);
    endtask

    task automatic t_busy_ignore();
        logic [8:0] held;
        load(9'h160);
        wbyte(8'h77); model[9'h160] = 8'h77;
        held = cur_addr;
        do_stop();
        load(9'h0AA);
        check("R11 load ignored", cur_addr, held);
        wbyte(8'hEE);
        cyc(0, '0, 0, '0, 1, 0);
        check("R11 wr/rd ignored", cur_addr, held);
        wait_free();
        do_stop();
        check("R11 nothing buffered", busy, 0);
        read_cmp("R11 data", 9'h160, 2);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fails++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 512; i++) model[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_full_page();
        t_overflow();
        t_partial();
        t_protect();
        t_empty_stop();
        t_mask_clear();
        t_read_wrap();
        t_busy_ignore();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end
endmodule